// File: doc/BRIEF.md
# Caption Line Inserter

This block holds two caption bytes that a host loads through a small register port. When captions are on, it replaces the luma samples of one chosen line in one chosen field with a caption waveform that carries those bytes. The waveform starts with a clock run-in, followed by a start pattern and then the sixteen data bits. Every bit is held for a fixed number of pixel clocks. The block drives a luma override stream and a valid flag, and a downstream mixer selects the override while the flag is high.

The host watches a ready-to-send flag to pace its loads. Writing the second byte marks a new pair as pending and drops the flag. When a packet starts, the block latches the bytes and raises the flag again. If no new pair has arrived since the last packet, the block sends null bytes. An optional mode replaces bit 7 of each byte with an odd-parity bit computed by the block.

Top module: `cc_line_inserter`

## Requirements
- R1: After reset, `rts` is 1, `cc_valid` is 0 and `cc_luma` is 0.
- R2: While the enable bit (control bit 6) is 0, no packet is emitted on any line.
- R3: A packet starts only when three conditions hold together: `line_num` equals `LINE_BASE` plus the 4-bit line select (control bits 3:0), `field_id` equals the field select (control bit 4), and `pix_pos` equals `START_POS`. `cc_valid` rises in the cycle after the clock edge at which `pix_pos` equals `START_POS`.
- R4: A packet is 33 bit periods of `BIT_CLKS` clocks each, so `cc_valid` stays high for 33*`BIT_CLKS` cycles. The bits appear in this order:
  - 14 run-in bits alternating 1,0, starting with 1;
  - the start bits 0, 0, 1;
  - the first byte, least significant bit first;
  - the second byte, least significant bit first.
- R5: While `cc_valid` is high, a 1 bit drives `HI_LVL` on `cc_luma` and a 0 bit drives `LO_LVL`. While `cc_valid` is low, `cc_luma` is 0.
- R6: With auto parity on (control bit 5 = 1), bit 7 of each sent byte is replaced so that the byte holds an odd number of ones.
- R7: With auto parity off, each byte is sent exactly as written, including bit 7.
- R8: Writing the second byte clears `rts` in the next cycle. The start of a packet sets `rts` again.
- R9: A packet that starts with no second-byte write since the previous packet sends 80h as both bytes.
- R10: The register addresses on `wr_addr` are:
  - 0: first byte;
  - 1: second byte;
  - 2: control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_num | input | LINE_W | Line count within the current field |
| field_id | input | 1 | Current field flag |
| pix_pos | input | POS_W | Horizontal sample position |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| cc_luma | output | LUMA_W | Luma override sample |
| cc_valid | output | 1 | Override active |
| rts | output | 1 | Host may load a new byte pair |

## Verification
The bench builds the block with `BIT_CLKS` = 4, so that a whole 33-bit packet fits in a short line scan. It samples each bit in the middle of its period. `LINE_BASE` = 10 and `START_POS` = 20 are kept, so the bench can step the line number and field flag just beside the target and confirm that nothing fires there. It also covers both parity modes, null-byte fallback after an unloaded packet, and the handshake flag around writes and packet starts.

// File: rtl/cc_pkg.sv
// Shared constants and helpers for the caption line inserter.
// Assumes the 33-bit packet layout: 14 run-in bits, 3 start bits, 16 data bits.
package cc_pkg;
    localparam int NBITS = 33;
    localparam logic [13:0] RUNIN = 14'h1555;   // sent LSB first: 1,0,1,0,...
    localparam logic [2:0]  START = 3'b100;     // sent LSB first: 0,0,1
    localparam logic [7:0]  NULL_BYTE = 8'h80;

    localparam logic [1:0] A_BYTE1 = 2'd0;
    localparam logic [1:0] A_BYTE2 = 2'd1;
    localparam logic [1:0] A_CTRL  = 2'd2;

    typedef struct packed {
        logic       enable;
        logic       auto_par;
        logic       fsel;
        logic [3:0] lsel;
    } cc_ctrl_t;

    // Forces bit 7 to odd parity over bits 6:0 when requested.
    function automatic logic [7:0] fix_parity(input logic [7:0] b, input logic on);
        return on ? {~(^b[6:0]), b[6:0]} : b;
    endfunction
endpackage

// File: rtl/cc_regs.sv
// Host register file and ready-to-send handshake.
// Assumes single-cycle writes. A second-byte write in the same cycle as a
// packet start wins over the start for the pending and rts state.
module cc_regs
    import cc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       take,
    output logic [7:0] byte1,
    output logic [7:0] byte2,
    output cc_ctrl_t   ctrl,
    output logic       pending,
    output logic       rts
);
    logic wr_b2;
    assign wr_b2 = wr_en && (wr_addr == A_BYTE2);

    // Data and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte1 <= '0;
            byte2 <= '0;
            ctrl  <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_BYTE1) byte1 <= wr_data;
            if (wr_addr == A_BYTE2) byte2 <= wr_data;
            if (wr_addr == A_CTRL)  ctrl  <= cc_ctrl_t'(wr_data[6:0]);
        end
    end

    // Pending flag and host handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            rts     <= 1'b1;
        end else if (wr_b2) begin
            pending <= 1'b1;
            rts     <= 1'b0;
        end else if (take) begin
            pending <= 1'b0;
            rts     <= 1'b1;
        end
    end

    AST_RTS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_b2 |=> !rts);                                        // R8
    AST_RTS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_b2) |=> rts);                              // R8
endmodule

// File: rtl/cc_frame.sv
// Builds the 33-bit packet word from the held bytes.
// Assumes a pair is sent only when pending; otherwise null bytes are used.
module cc_frame
    import cc_pkg::*;
(
    input  logic [7:0]       byte1,
    input  logic [7:0]       byte2,
    input  logic             pending,
    input  logic             auto_par,
    output logic [NBITS-1:0] frame
);
    logic [7:0] d1, d2;

    // Select the bytes, apply parity and pack them in the order they are sent.
    always_comb begin
        d1 = fix_parity(pending ? byte1 : NULL_BYTE, auto_par);
        d2 = fix_parity(pending ? byte2 : NULL_BYTE, auto_par);
        frame = {d2, d1, START, RUNIN};
    end
endmodule

// File: rtl/cc_serializer.sv
// Shifts a packet out one bit per BIT_CLKS clocks and maps each bit to luma levels.
// Assumes start is never asserted while a packet is in flight.
module cc_serializer
    import cc_pkg::*;
#(
    parameter int          BIT_CLKS = 27,
    parameter int          LUMA_W   = 8,
    parameter logic [LUMA_W-1:0] HI_LVL = LUMA_W'(130),
    parameter logic [LUMA_W-1:0] LO_LVL = LUMA_W'(16)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NBITS-1:0]  frame,
    output logic              busy,
    output logic [LUMA_W-1:0] luma
);
    localparam int TW = $clog2(BIT_CLKS + 1);
    localparam int IW = $clog2(NBITS + 1);

    logic [NBITS-1:0] shreg;
    logic [TW-1:0]    tick;
    logic [IW-1:0]    idx;

    // Bit timer, bit index and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            shreg <= '0;
            tick  <= '0;
            idx   <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            shreg <= frame;
            tick  <= '0;
            idx   <= '0;
        end else if (busy) begin
            if (tick == TW'(BIT_CLKS - 1)) begin
                tick  <= '0;
                shreg <= shreg >> 1;
                if (idx == IW'(NBITS - 1)) busy <= 1'b0;
                else                       idx  <= idx + 1'b1;
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end

    // Output level for the current bit.
    always_comb begin
        if (!busy)         luma = '0;
        else if (shreg[0]) luma = HI_LVL;
        else               luma = LO_LVL;
    end

    logic [15:0] run_len;
    // Length of the current packet, for the length check only.
    always_ff @(posedge clk) begin
        if (!rst_n)     run_len <= '0;
        else if (start) run_len <= '0;
        else if (busy)  run_len <= run_len + 1'b1;
    end

    AST_PKT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_len == 16'(NBITS * BIT_CLKS));       // R4
    AST_FIRST_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && luma == HI_LVL));                    // R4
    AST_TWO_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (luma == HI_LVL || luma == LO_LVL));           // R5
endmodule

// File: rtl/cc_line_inserter.sv
// Caption line inserter top: host registers, target-line trigger, packet
// builder and serializer. Assumes pix_pos passes START_POS once per line.
module cc_line_inserter
    import cc_pkg::*;
#(
    parameter int LINE_W    = 10,
    parameter int POS_W     = 11,
    parameter int LUMA_W    = 8,
    parameter int BIT_CLKS  = 27,
    parameter int LINE_BASE = 10,
    parameter int START_POS = 20,
    parameter logic [LUMA_W-1:0] HI_LVL = LUMA_W'(130),
    parameter logic [LUMA_W-1:0] LO_LVL = LUMA_W'(16)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_id,
    input  logic [POS_W-1:0]  pix_pos,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    output logic [LUMA_W-1:0] cc_luma,
    output logic              cc_valid,
    output logic              rts
);
    logic [7:0]       byte1, byte2;
    cc_ctrl_t         ctrl;
    logic             pending, start;
    logic [NBITS-1:0] frame;
    logic [LINE_W-1:0] target;

    cc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .take(start), .byte1(byte1), .byte2(byte2),
        .ctrl(ctrl), .pending(pending), .rts(rts)
    );

    cc_frame u_frame (
        .byte1(byte1), .byte2(byte2), .pending(pending),
        .auto_par(ctrl.auto_par), .frame(frame)
    );

    // Trigger on the selected line, field and start position.
    always_comb begin
        target = LINE_W'(LINE_BASE) + LINE_W'(ctrl.lsel);
        start  = ctrl.enable && !cc_valid && (line_num == target)
              && (field_id == ctrl.fsel) && (pix_pos == POS_W'(START_POS));
    end

    cc_serializer #(
        .BIT_CLKS(BIT_CLKS), .LUMA_W(LUMA_W), .HI_LVL(HI_LVL), .LO_LVL(LO_LVL)
    ) u_ser (
        .clk(clk), .rst_n(rst_n), .start(start), .frame(frame),
        .busy(cc_valid), .luma(cc_luma)
    );

    AST_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ctrl.auto_par) |-> (^frame[24:17] && ^frame[32:25]));  // R6
    AST_NULL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !pending) |-> frame[32:17] == 16'h8080);      // R9
    AST_NO_START_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.enable |=> !$rose(cc_valid));                     // R2
endmodule

// File: tb/test_cc_line_inserter.sv
module test_cc_line_inserter;
    localparam int BC = 4;
    localparam int SP = 20;
    localparam int LB = 10;
    localparam logic [7:0] HI = 8'd130;
    localparam logic [7:0] LO = 8'd16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [9:0] line_num = '0;
    logic field_id = 1'b0;
    logic [10:0] pix_pos = '0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] cc_luma;
    logic cc_valid, rts;

    int n_chk = 0, n_bad = 0;
    logic [32:0] got_bits;
    int vcount, first_at, lvl_bad;

    always #4 clk = ~clk;

    cc_line_inserter #(.BIT_CLKS(BC), .LINE_BASE(LB), .START_POS(SP)) i_cc_line_inserter (
        .clk(clk), .rst_n(rst_n), .line_num(line_num), .field_id(field_id),
        .pix_pos(pix_pos), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cc_luma(cc_luma), .cc_valid(cc_valid), .rts(rts)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    function automatic logic [32:0] expect_frame(input logic [7:0] b1, input logic [7:0] b2);
        logic [32:0] f;
        for (int i = 0; i < 14; i++) f[i] = (i % 2 == 0);
        f[14] = 1'b0; f[15] = 1'b0; f[16] = 1'b1;
        for (int i = 0; i < 8; i++) begin
            f[17 + i] = b1[i];
            f[25 + i] = b2[i];
        end
        return f;
    endfunction

    function automatic logic [7:0] oddp(input logic [7:0] b);
        return {~(^b[6:0]), b[6:0]};
    endfunction

    // Sweep one line and collect the packet bits, sampled mid-bit.
    task automatic scan(input int ln, input logic fld);
        got_bits = '0; vcount = 0; first_at = -1; lvl_bad = 0;
        line_num = 10'(ln); field_id = fld;
        for (int p = 0; p < SP + 33 * BC + 12; p++) begin
            @(negedge clk);
            if (cc_valid) begin
                if (first_at < 0) first_at = p;
                if (cc_luma != HI && cc_luma != LO) lvl_bad++;
                if (vcount % BC == BC / 2 && vcount / BC < 33)
                    got_bits[vcount / BC] = (cc_luma == HI);
                vcount++;
            end else if (cc_luma != 8'd0) lvl_bad++;
            pix_pos = 11'(p);
        end
        pix_pos = '0;
    endtask

    task automatic t_reset();
        check("R1 rts", rts, 1);
        check("R1 valid", cc_valid, 0);
        check("R1 luma", cc_luma, 0);
    endtask

    task automatic t_disabled();
        wr(2'd2, 8'h23);                // enable off, line sel 3
        scan(LB + 3, 1'b0);
        check("R2 no packet when disabled", vcount, 0);
    endtask

    task automatic t_parity_on();
        wr(2'd2, 8'h75);                // enable, auto parity, field 1, line 5
        wr(2'd0, 8'h41);
        wr(2'd1, 8'h03);
        check("R8 rts cleared by byte2", rts, 0);
        scan(LB + 4, 1'b1);
        check("R3 wrong line", vcount, 0);
        scan(LB + 5, 1'b0);
        check("R3 wrong field", vcount, 0);
        scan(LB + 5, 1'b1);
        check("R3 start timing", first_at, SP + 1);
        check("R4 packet length", vcount, 33 * BC);
        check("R4 R6 R10 bits", got_bits, expect_frame(oddp(8'h41), oddp(8'h03)));
        check("R5 levels", lvl_bad, 0);
        check("R8 rts set after start", rts, 1);
    endtask

    task automatic t_null();
        scan(LB + 5, 1'b1);
        check("R9 null bytes", got_bits, expect_frame(8'h80, 8'h80));
        check("R9 length", vcount, 33 * BC);
    endtask

    task automatic t_parity_off();
        wr(2'd2, 8'h40);                // enable, no parity, field 0, line 0
        wr(2'd0, 8'h12);
        wr(2'd1, 8'hF3);
        scan(LB, 1'b0);
        check("R7 bytes as written", got_bits, expect_frame(8'h12, 8'hF3));
        check("R5 levels", lvl_bad, 0);
        check("R8 rts after packet", rts, 1);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_disabled();
                t_parity_on();
                t_null();
                t_parity_off();
            end
            begin
                repeat (20000) @(negedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule